// File: doc/BRIEF.md
# Chunk Residency Directory

This block keeps a directory of which whole data chunks currently live in an accelerator's local memory. The memory is cut into a fixed number of equal slots, each large enough for one chunk. Every slot has one directory entry holding the chunk identifier, the chunk's size once known, and a two-bit state. Compute kernels present a chunk identifier on the request port. The directory compares it against every entry in the same cycle and picks one of four outcomes. The chunk may be resident, so the transfer can start now. It may already be on its way, so the request is merged. A free entry may be claimed and a fetch sent to the host agent. If none of these applies, the request stalls.

The host agent answers each fetch with a fill completion carrying the identifier and the size. That completion turns the pending entry valid. One cycle later a ready pulse announces the slot index and size, which all waiting requesters share. A release input returns a valid entry to the free pool. Entry states are encoded as free `2'b00`, pending `2'b01` and valid `2'b10`.

Top module: `chunk_dir_ctrl`

## Requirements
- R1: After reset every entry is free, and `req_ack`, `miss_valid` and `ready_valid` are low; `req_ack` is never high in a cycle without `req_valid`.
- R2: A request whose identifier matches a valid entry is acknowledged in the same cycle with `req_now` high, `req_slot` set to that entry's index and `req_size` set to its stored size, and no fetch is issued.
- R3: A request whose identifier matches no valid or pending entry, while some entry is free, is acknowledged in the same cycle with `req_now` low. In that same cycle `miss_valid` is high with `miss_id` equal to the request identifier and `miss_slot` equal to `req_slot`, and the claimed entry is pending from the next cycle.
- R4: When several entries are free, the allocation takes the lowest-indexed free entry.
- R5: A request whose identifier matches a pending entry is acknowledged with `req_now` low and `req_slot` set to the pending entry's index, and no second fetch is issued.
- R6: A request whose identifier is absent while no entry is free is not acknowledged and issues no fetch. It is accepted in the first cycle after an entry has been released.
- R7: A fill completion whose identifier matches a pending entry makes that entry valid with the given size. In the next cycle `ready_valid` is high for one cycle with `ready_slot` and `ready_size`. A fill that matches no pending entry changes nothing and produces no ready pulse.
- R8: A release whose identifier matches a valid entry frees it, so a later request for that identifier misses. A release that matches no valid entry, including a pending one, has no effect. A request in the same cycle as the release of its own chunk still sees it resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Kernel presents a chunk request |
| req_id | input | ID_W | Requested chunk identifier |
| req_ack | output | 1 | Request accepted this cycle |
| req_now | output | 1 | Chunk resident, transfer may start now |
| req_slot | output | SLOT_W | Slot bound to the accepted request |
| req_size | output | SIZE_W | Stored chunk size on a resident hit |
| miss_valid | output | 1 | Fetch request to the host agent |
| miss_id | output | ID_W | Chunk identifier to fetch |
| miss_slot | output | SLOT_W | Slot reserved for the fetched chunk |
| fill_valid | input | 1 | Host reports a completed fill |
| fill_id | input | ID_W | Identifier of the filled chunk |
| fill_size | input | SIZE_W | Size of the filled chunk |
| rel_valid | input | 1 | Release request |
| rel_id | input | ID_W | Identifier of the chunk to free |
| ready_valid | output | 1 | A pending chunk has become resident |
| ready_slot | output | SLOT_W | Slot of the newly resident chunk |
| ready_size | output | SIZE_W | Size of the newly resident chunk |

## Verification
The bench targets the interactions that only occur when events collide. One case is a request arriving in the same cycle as the fill of its chunk: it must still be merged, and a design that looked at the post-fill state would report it resident a cycle early. Another is a request meeting the release of its own chunk: a design that let the release win would issue a needless fetch. The bench also sends a second request for a chunk already in flight; a design that skipped the pending comparison would fetch twice and bind two slots to one identifier. It fills the directory to force stalls, then checks that a release of a merely pending entry does not unblock them and that the lowest free slot is chosen once a real release lands. A mis-ordered priority encoder or a release gate on the wrong state shows up as a wrong slot or an early acknowledge.

// File: rtl/chunk_dir_pkg.sv
package chunk_dir_pkg;

  typedef enum logic [1:0] {
    ST_FREE  = 2'b00,
    ST_PEND  = 2'b01,
    ST_VALID = 2'b10
  } slot_state_e;

  typedef enum logic [2:0] {
    OC_IDLE,
    OC_HIT,
    OC_MERGE,
    OC_ALLOC,
    OC_STALL
  } outcome_e;

  // Priority of the lookup outcomes: resident, in flight, claim, stall.
  function automatic outcome_e classify(input logic valid, input logic hit,
                                        input logic pend, input logic free);
    if (!valid)     return OC_IDLE;
    else if (hit)   return OC_HIT;
    else if (pend)  return OC_MERGE;
    else if (free)  return OC_ALLOC;
    else            return OC_STALL;
  endfunction

endpackage

// File: rtl/dir_match.sv
module dir_match
  import chunk_dir_pkg::*;
#(
  parameter int          NUM_SLOTS = 8,
  parameter int          ID_W      = 16,
  parameter slot_state_e WANT      = ST_VALID
) (
  input  slot_state_e           st_i  [NUM_SLOTS],
  input  logic [ID_W-1:0]       id_i  [NUM_SLOTS],
  input  logic [ID_W-1:0]       key_i,
  output logic [NUM_SLOTS-1:0]  vec_o
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign vec_o[g] = (st_i[g] == WANT) && (id_i[g] == key_i);
  end

endmodule

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input  logic [NUM_SLOTS-1:0] vec_i,
  output logic                 any_o,
  output logic [SLOT_W-1:0]    idx_o
);

  // Lowest set bit wins: scan from the top so the last write is the lowest.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = SLOT_W'(i);
      end
    end
  end

endmodule

// File: rtl/dir_entry.sv
module dir_entry
  import chunk_dir_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int SIZE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [ID_W-1:0]    alloc_id,
  input  logic               fill_en,
  input  logic [SIZE_W-1:0]  fill_size,
  input  logic               rel_en,
  output slot_state_e        st_o,
  output logic [ID_W-1:0]    id_o,
  output logic [SIZE_W-1:0]  size_o
);

  // The three enables act on distinct states, so at most one is ever high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_o   <= ST_FREE;
      id_o   <= '0;
      size_o <= '0;
    end else if (rel_en) begin
      st_o   <= ST_FREE;
    end else if (alloc_en) begin
      st_o   <= ST_PEND;
      id_o   <= alloc_id;
      size_o <= '0;
    end else if (fill_en) begin
      st_o   <= ST_VALID;
      size_o <= fill_size;
    end
  end

endmodule

// File: rtl/chunk_dir_ctrl.sv
module chunk_dir_ctrl
  import chunk_dir_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 16,
  parameter int SIZE_W    = 12,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ID_W-1:0]    req_id,
  output logic               req_ack,
  output logic               req_now,
  output logic [SLOT_W-1:0]  req_slot,
  output logic [SIZE_W-1:0]  req_size,
  output logic               miss_valid,
  output logic [ID_W-1:0]    miss_id,
  output logic [SLOT_W-1:0]  miss_slot,
  input  logic               fill_valid,
  input  logic [ID_W-1:0]    fill_id,
  input  logic [SIZE_W-1:0]  fill_size,
  input  logic               rel_valid,
  input  logic [ID_W-1:0]    rel_id,
  output logic               ready_valid,
  output logic [SLOT_W-1:0]  ready_slot,
  output logic [SIZE_W-1:0]  ready_size
);

  slot_state_e           st     [NUM_SLOTS];
  logic [ID_W-1:0]       ent_id [NUM_SLOTS];
  logic [SIZE_W-1:0]     ent_sz [NUM_SLOTS];

  // Named internal events, brought out for the checker.
  logic [NUM_SLOTS-1:0]   hit_vec, pend_vec, free_vec, fill_vec, rel_vec;
  logic [NUM_SLOTS-1:0]   alloc_vec, fill_en, rel_en;
  logic [2*NUM_SLOTS-1:0] st_flat;
  logic                   hit_any, pend_any, free_any, fill_hit;
  logic [SLOT_W-1:0]      hit_idx, pend_idx, free_idx, fill_idx;
  outcome_e               oc;

  // Parallel lookups: request against resident and in-flight entries,
  // fill against in-flight entries, release against resident entries.
  dir_match #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .WANT(ST_VALID)) u_m_hit (
    .st_i(st), .id_i(ent_id), .key_i(req_id), .vec_o(hit_vec));
  dir_match #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .WANT(ST_PEND)) u_m_pend (
    .st_i(st), .id_i(ent_id), .key_i(req_id), .vec_o(pend_vec));
  dir_match #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .WANT(ST_PEND)) u_m_fill (
    .st_i(st), .id_i(ent_id), .key_i(fill_id), .vec_o(fill_vec));
  dir_match #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .WANT(ST_VALID)) u_m_rel (
    .st_i(st), .id_i(ent_id), .key_i(rel_id), .vec_o(rel_vec));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_free
    assign free_vec[g] = (st[g] == ST_FREE);
    assign st_flat[2*g +: 2] = st[g];
  end

  dir_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_p_hit (
    .vec_i(hit_vec), .any_o(hit_any), .idx_o(hit_idx));
  dir_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_p_pend (
    .vec_i(pend_vec), .any_o(pend_any), .idx_o(pend_idx));
  dir_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_p_free (
    .vec_i(free_vec), .any_o(free_any), .idx_o(free_idx));
  dir_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_p_fill (
    .vec_i(fill_vec), .any_o(fill_hit), .idx_o(fill_idx));

  assign oc = classify(req_valid, hit_any, pend_any, free_any);

  always_comb begin
    req_ack    = 1'b0;
    req_now    = 1'b0;
    req_slot   = '0;
    req_size   = '0;
    miss_valid = 1'b0;
    unique case (oc)
      OC_HIT: begin
        req_ack  = 1'b1;
        req_now  = 1'b1;
        req_slot = hit_idx;
        req_size = ent_sz[hit_idx];
      end
      OC_MERGE: begin
        req_ack  = 1'b1;
        req_slot = pend_idx;
      end
      OC_ALLOC: begin
        req_ack    = 1'b1;
        req_slot   = free_idx;
        miss_valid = 1'b1;
      end
      default: ;
    endcase
  end

  assign miss_id   = req_id;
  assign miss_slot = free_idx;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_ent
    assign alloc_vec[g] = (oc == OC_ALLOC) && (free_idx == SLOT_W'(g));
    assign fill_en[g]   = fill_valid && fill_vec[g];
    assign rel_en[g]    = rel_valid && rel_vec[g];

    dir_entry #(.ID_W(ID_W), .SIZE_W(SIZE_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_vec[g]),
      .alloc_id  (req_id),
      .fill_en   (fill_en[g]),
      .fill_size (fill_size),
      .rel_en    (rel_en[g]),
      .st_o      (st[g]),
      .id_o      (ent_id[g]),
      .size_o    (ent_sz[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_valid <= 1'b0;
      ready_slot  <= '0;
      ready_size  <= '0;
    end else begin
      ready_valid <= fill_valid && fill_hit;
      ready_slot  <= fill_idx;
      ready_size  <= fill_size;
    end
  end

endmodule

// File: rtl/chunk_dir_ctrl_chk.sv
module chunk_dir_ctrl_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 16,
  parameter int SLOT_W    = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [ID_W-1:0]        req_id,
  input logic                   req_ack,
  input logic                   req_now,
  input logic                   miss_valid,
  input logic [ID_W-1:0]        miss_id,
  input logic [SLOT_W-1:0]      miss_slot,
  input logic                   fill_valid,
  input logic                   fill_hit,
  input logic                   ready_valid,
  input logic [NUM_SLOTS-1:0]   alloc_vec,
  input logic [NUM_SLOTS-1:0]   rel_en,
  input logic [2*NUM_SLOTS-1:0] st_flat
);

  p_no_ack_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ack);

  p_now_is_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_now |-> req_ack);

  p_miss_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (req_ack && !req_now && miss_id == req_id));

  p_claim_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (st_flat[$past(miss_slot)*2 +: 2] == 2'b01));

  p_single_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |-> !miss_valid);

  p_ready_follows_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_hit) |=> ready_valid);

  p_ready_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_valid |-> $past(fill_valid && fill_hit));

  p_single_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rel_en) <= 1);

endmodule

bind chunk_dir_ctrl chunk_dir_ctrl_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .SLOT_W(SLOT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .req_ack(req_ack), .req_now(req_now), .miss_valid(miss_valid),
  .miss_id(miss_id), .miss_slot(miss_slot), .fill_valid(fill_valid),
  .fill_hit(fill_hit), .ready_valid(ready_valid), .alloc_vec(alloc_vec),
  .rel_en(rel_en), .st_flat(st_flat)
);

// File: tb/chunk_dir_ctrl_tb_top.sv
module chunk_dir_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS     = 4;
  localparam int ID_W   = 8;
  localparam int SIZE_W = 8;
  localparam int SW     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0, rel_valid = 1'b0;
  logic [ID_W-1:0] req_id = '0, fill_id = '0, rel_id = '0;
  logic [SIZE_W-1:0] fill_size = '0;
  logic req_ack, req_now, miss_valid, ready_valid;
  logic [SW-1:0] req_slot, miss_slot, ready_slot;
  logic [SIZE_W-1:0] req_size, ready_size;
  logic [ID_W-1:0] miss_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  chunk_dir_ctrl #(.NUM_SLOTS(NS), .ID_W(ID_W), .SIZE_W(SIZE_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_id(req_id), .req_ack(req_ack),
    .req_now(req_now), .req_slot(req_slot), .req_size(req_size),
    .miss_valid(miss_valid), .miss_id(miss_id), .miss_slot(miss_slot),
    .fill_valid(fill_valid), .fill_id(fill_id), .fill_size(fill_size),
    .rel_valid(rel_valid), .rel_id(rel_id),
    .ready_valid(ready_valid), .ready_slot(ready_slot), .ready_size(ready_size)
  );

  int n_total = 0;
  int n_fail  = 0;

  // Reference model: 0 free, 1 in flight, 2 resident.
  int m_st [NS];
  int m_id [NS];
  int m_sz [NS];
  bit exp_rdy = 1'b0;
  int exp_rdy_slot = 0;
  int exp_rdy_sz = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NS; i++) begin
      m_st[i] = 0; m_id[i] = 0; m_sz[i] = 0;
    end
    exp_rdy = 1'b0;
  endfunction

  // One cycle: drive, compare, clock, advance the model.
  task automatic step(input bit rv, input int rid, input bit fv, input int fid,
                      input int fsz, input bit lv, input int lid);
    int hit, pend, fre, fslot, lslot;
    string tag;
    @(negedge clk);
    req_valid = rv; req_id = ID_W'(rid);
    fill_valid = fv; fill_id = ID_W'(fid); fill_size = SIZE_W'(fsz);
    rel_valid = lv; rel_id = ID_W'(lid);
    #1;
    hit = -1; pend = -1; fre = -1; fslot = -1; lslot = -1;
    for (int i = NS - 1; i >= 0; i--) begin
      if (m_st[i] == 2 && m_id[i] == rid) hit = i;
      if (m_st[i] == 1 && m_id[i] == rid) pend = i;
      if (m_st[i] == 0) fre = i;
      if (m_st[i] == 1 && m_id[i] == fid) fslot = i;
      if (m_st[i] == 2 && m_id[i] == lid) lslot = i;
    end
    if (!rv) begin
      chk("R1", "ack idle", int'(req_ack), 0);
      chk("R1", "miss idle", int'(miss_valid), 0);
    end else if (hit >= 0) begin
      tag = "R2";
      chk(tag, "ack", int'(req_ack), 1);
      chk(tag, "now", int'(req_now), 1);
      chk(tag, "slot", int'(req_slot), hit);
      chk(tag, "size", int'(req_size), m_sz[hit]);
      chk(tag, "no miss", int'(miss_valid), 0);
    end else if (pend >= 0) begin
      tag = "R5";
      chk(tag, "ack", int'(req_ack), 1);
      chk(tag, "now", int'(req_now), 0);
      chk(tag, "slot", int'(req_slot), pend);
      chk(tag, "no miss", int'(miss_valid), 0);
    end else if (fre >= 0) begin
      chk("R3", "ack", int'(req_ack), 1);
      chk("R3", "now", int'(req_now), 0);
      chk("R3", "miss", int'(miss_valid), 1);
      chk("R3", "miss id", int'(miss_id), rid);
      chk("R4", "slot", int'(req_slot), fre);
      chk("R4", "miss slot", int'(miss_slot), fre);
    end else begin
      chk("R6", "ack", int'(req_ack), 0);
      chk("R6", "miss", int'(miss_valid), 0);
    end
    chk("R7", "ready", int'(ready_valid), int'(exp_rdy));
    if (exp_rdy && ready_valid) begin
      chk("R7", "ready slot", int'(ready_slot), exp_rdy_slot);
      chk("R7", "ready size", int'(ready_size), exp_rdy_sz);
    end
    @(posedge clk);
    exp_rdy = 1'b0;
    if (rv && hit < 0 && pend < 0 && fre >= 0) begin
      m_st[fre] = 1; m_id[fre] = rid; m_sz[fre] = 0;
    end
    if (fv && fslot >= 0) begin
      m_st[fslot] = 2; m_sz[fslot] = fsz;
      exp_rdy = 1'b1; exp_rdy_slot = fslot; exp_rdy_sz = fsz;
    end
    if (lv && lslot >= 0) m_st[lslot] = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_total++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state at the ports
    #1;
    chk("R1", "ack after reset", int'(req_ack), 0);
    chk("R1", "ready after reset", int'(ready_valid), 0);
    idle();
    // R3/R4: first miss claims slot 0, R5: repeat merges
    step(1, 10, 0, 0, 0, 0, 0);
    step(1, 10, 0, 0, 0, 0, 0);
    step(1, 20, 0, 0, 0, 0, 0);
    // R7 with R5: request in the fill cycle still merges
    step(1, 10, 1, 10, 5, 0, 0);
    step(1, 10, 0, 0, 0, 0, 0);   // R2 hit, ready pulse checked here
    // R7: fill of an unknown chunk is ignored
    step(0, 0, 1, 99, 3, 0, 0);
    idle();
    // R4/R6: fill the directory then stall
    step(1, 30, 0, 0, 0, 0, 0);
    step(1, 40, 0, 0, 0, 0, 0);
    step(1, 50, 0, 0, 0, 0, 0);
    // R8: releasing an in-flight chunk does nothing, stall persists
    step(1, 50, 0, 0, 0, 1, 20);
    step(1, 50, 1, 20, 7, 0, 0);
    idle();
    step(1, 50, 0, 0, 0, 1, 20);  // still stalled this cycle
    step(1, 50, 0, 0, 0, 0, 0);   // R6: accepted into slot 1
    chk("R6", "accepted after release", int'(req_ack), 1);
    chk("R6", "freed slot reused", int'(req_slot), 1);
    // R8: request beside release of its own chunk still hits
    step(1, 10, 0, 0, 0, 1, 10);
    step(1, 10, 0, 0, 0, 0, 0);
    chk("R8", "released chunk misses", int'(miss_valid), 1);
    // R8: release of an absent chunk leaves residents intact
    step(0, 0, 1, 30, 9, 0, 0);
    step(0, 0, 0, 0, 0, 1, 77);
    step(1, 30, 0, 0, 0, 0, 0);
    chk("R8", "resident kept", int'(req_now), 1);
    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      int r = int'($urandom_range(0, 99));
      step(r < 60, int'($urandom_range(1, 6)),
           r % 3 == 0, int'($urandom_range(1, 6)), int'($urandom_range(1, 200)),
           r % 7 == 0, int'($urandom_range(1, 6)));
    end
    idle();
    summary();
  end

endmodule